// File: doc/BRIEF.md
# Device Register Window Decoder

This block owns one configuration word that places a window of memory-mapped device registers in a 36-bit physical address space, and it classifies each physical request address against that window. The window always starts on a 32 KB boundary. It is built from a preset number of 64-byte device register blocks. A request that lands inside the window while the window is switched on is claimed by the device logic. The block reports a hit and the index of the 64-byte block addressed. Any other request falls through to ordinary system memory.

Software reaches the configuration word through a 32-bit read/write port. Only the base address and the on/off bit can be written. The block count and a flag that marks block 0 as reserved for window-control registers are fixed by parameters. A permission input gates every register access: without permission, reads return zero and writes are dropped. The implemented physical address width is a parameter. Base bits above that width are not stored and always read as zero.

Top module: `dev_window_decoder`

## Requirements
- R1: After a synchronous reset the enable bit (bit 10) and all stored base bits read 0, and no request hits.
- R2: A write with `access_ok`=1 stores data bits 31..11 as physical address bits 35..15 of the window base and bit 10 as the enable. The new value appears on `reg_rd_data` in the cycle after the write edge.
- R3: Register bits whose physical address bit (register bit + 4) is at or above `PA_WIDTH` ignore writes and read 0. With the default `PA_WIDTH`=32 these are bits 31..28.
- R4: Bit 9 reads the `PRESET_CTRL` parameter and bits 8..0 read `PRESET_SIZE` (default 1 and 5). Writes never change either field.
- R5: While `access_ok`=0, `reg_rd_data` is all zeros and writes leave the stored word unchanged.
- R6: With the enable bit 0, no request hits, whatever its address.
- R7: A hit requires `req_addr[35:15]` to equal the stored base, including the base bits that read as zero.
- R8: A hit requires the block index `req_addr[14:6]` to be no greater than `PRESET_SIZE`. Index `PRESET_SIZE` hits and index `PRESET_SIZE`+1 misses.
- R9: On a hit, `win_blk` equals `req_addr[14:6]`. On a miss, it is 0.
- R10: `win_hit` and `win_blk` follow `req_addr` combinationally in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_ok | input | 1 | Register access permission for the current context |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| req_addr | input | 36 | Physical request address |
| win_hit | output | 1 | Request is claimed by the device window |
| win_blk | output | 9 | Index of the 64-byte block addressed, 0 on a miss |

## Verification
The decode is exercised with these request addresses:
- Addresses at the first and last in-range block. These confirm the inclusive size bound.
- The address one block past the end and the top of the 32 KB page. These must miss even though the base matches.
- A neighbouring 32 KB page. This separates base comparison from index checking.
- An address whose only difference is an unimplemented high bit. This shows the tied-zero base bits take part in the compare.

Each hit pattern is then repeated with the enable cleared, to tell the enable gate apart from the address match. On the register side, an all-ones write separates writable, unimplemented and preset bits. A write attempted without permission, followed by a read with permission, shows that the dropped write left the stored word untouched.

// File: rtl/dwin_pkg.sv
package dwin_pkg;

    localparam int PADDR_W  = 36;
    localparam int REG_W    = 32;
    localparam int BASE_W   = 21;
    localparam int BLK_W    = 9;
    localparam int BASE_LSB = 15;
    localparam int BLK_LSB  = 6;

    // Register image, MSB first: base, enable, control-block flag, size
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              en;
        logic              ctrl;
        logic [BLK_W-1:0]  size;
    } win_reg_t;

    typedef struct packed {
        logic             hit;
        logic [BLK_W-1:0] blk;
    } win_resp_t;

    // Base bit i maps to physical address bit i+BASE_LSB
    function automatic logic base_bit_impl(int pa_w, int i);
        return (i + BASE_LSB) < pa_w;
    endfunction

    function automatic logic [BASE_W-1:0] base_mask(int pa_w);
        logic [BASE_W-1:0] m;
        for (int i = 0; i < BASE_W; i++) m[i] = base_bit_impl(pa_w, i);
        return m;
    endfunction

endpackage

// File: rtl/dwin_cfg_reg.sv
module dwin_cfg_reg
    import dwin_pkg::*;
#(
    parameter int              PA_WIDTH    = 32,
    parameter logic            PRESET_CTRL = 1'b1,
    parameter logic [BLK_W-1:0] PRESET_SIZE = 9'd5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access_ok,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [BASE_W-1:0] base_o,
    output logic              en_o
);

    win_reg_t wr_img;
    win_reg_t rd_img;
    logic     wr_go;

    assign wr_img = win_reg_t'(wr_data);
    assign wr_go  = wr_en && access_ok;

    // One flop per implemented base bit; the rest are tied to zero
    for (genvar g = 0; g < BASE_W; g++) begin : g_base
        if (base_bit_impl(PA_WIDTH, g)) begin : g_flop
            logic q;
            always_ff @(posedge clk) begin
                if (rst)        q <= 1'b0;
                else if (wr_go) q <= wr_img.base[g];
            end
            assign base_o[g] = q;
        end else begin : g_zero
            assign base_o[g] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        en_o <= 1'b0;
        else if (wr_go) en_o <= wr_img.en;
    end

    always_comb begin
        rd_img.base = base_o;
        rd_img.en   = en_o;
        rd_img.ctrl = PRESET_CTRL;
        rd_img.size = PRESET_SIZE;
        rd_data     = access_ok ? REG_W'(rd_img) : '0;
    end

endmodule

// File: rtl/dwin_match.sv
module dwin_match
    import dwin_pkg::*;
(
    input  logic [PADDR_W-1:0] addr,
    input  logic [BASE_W-1:0]  base,
    input  logic               en,
    input  logic [BLK_W-1:0]   size,
    output win_resp_t          resp
);

    logic [BASE_W-1:0] page;
    logic [BLK_W-1:0]  idx;
    logic              page_eq;
    logic              in_range;

    always_comb begin
        page     = addr[PADDR_W-1:BASE_LSB];
        idx      = addr[BASE_LSB-1:BLK_LSB];
        page_eq  = (page == base);
        in_range = (idx <= size);
        resp.hit = en && page_eq && in_range;
        resp.blk = resp.hit ? idx : '0;
    end

endmodule

// File: rtl/dev_window_decoder.sv
module dev_window_decoder
    import dwin_pkg::*;
#(
    parameter int               PA_WIDTH    = 32,
    parameter logic             PRESET_CTRL = 1'b1,
    parameter logic [8:0]       PRESET_SIZE = 9'd5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        access_ok,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic [35:0] req_addr,
    output logic        win_hit,
    output logic [8:0]  win_blk
);

    logic [BASE_W-1:0] base_q;
    logic              en_q;
    win_resp_t         resp;

    dwin_cfg_reg #(
        .PA_WIDTH   (PA_WIDTH),
        .PRESET_CTRL(PRESET_CTRL),
        .PRESET_SIZE(PRESET_SIZE)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .access_ok(access_ok),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .rd_data  (reg_rd_data),
        .base_o   (base_q),
        .en_o     (en_q)
    );

    dwin_match u_match (
        .addr(req_addr),
        .base(base_q),
        .en  (en_q),
        .size(PRESET_SIZE),
        .resp(resp)
    );

    assign win_hit = resp.hit;
    assign win_blk = resp.blk;

endmodule

// File: rtl/dev_window_decoder_chk.sv
module dev_window_decoder_chk
    import dwin_pkg::*;
#(
    parameter int         PA_WIDTH    = 32,
    parameter logic       PRESET_CTRL = 1'b1,
    parameter logic [8:0] PRESET_SIZE = 9'd5
) (
    input logic        clk,
    input logic        rst,
    input logic        access_ok,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic [35:0] req_addr,
    input logic        win_hit,
    input logic [8:0]  win_blk,
    input logic [20:0] base_q,
    input logic        en_q
);

    localparam logic [20:0] UNIMPL = ~base_mask(PA_WIDTH);

    a_r2_write_enable: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && access_ok) |=> (en_q == $past(reg_wr_data[10])));

    a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[31:11] & UNIMPL) == 21'd0);

    a_r4_preset_fields: assert property (@(posedge clk) disable iff (rst)
        access_ok |-> (reg_rd_data[9:0] == {PRESET_CTRL, PRESET_SIZE}));

    a_r5_read_blocked: assert property (@(posedge clk) disable iff (rst)
        !access_ok |-> (reg_rd_data == 32'd0));

    a_r5_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !access_ok) |=> ($stable(base_q) && $stable(en_q)));

    a_r6_hit_needs_en: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> en_q);

    a_r7_hit_page: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (req_addr[35:15] == base_q));

    a_r8_hit_in_range: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (req_addr[14:6] <= PRESET_SIZE));

    a_r9_blk_on_miss: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> (win_blk == 9'd0));

    a_r9_blk_on_hit: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (win_blk == req_addr[14:6]));

endmodule

bind dev_window_decoder dev_window_decoder_chk #(
    .PA_WIDTH   (PA_WIDTH),
    .PRESET_CTRL(PRESET_CTRL),
    .PRESET_SIZE(PRESET_SIZE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .access_ok  (access_ok),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data),
    .req_addr   (req_addr),
    .win_hit    (win_hit),
    .win_blk    (win_blk),
    .base_q     (base_q),
    .en_q       (en_q)
);

// File: tb/dev_window_decoder_tb.sv
module dev_window_decoder_tb;

    localparam logic [35:0] B = 36'h0_8765_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        access_ok = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [35:0] req_addr = '0;
    logic        win_hit;
    logic [8:0]  win_blk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dev_window_decoder u_dut (
        .clk(clk), .rst(rst), .access_ok(access_ok),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .req_addr(req_addr),
        .win_hit(win_hit), .win_blk(win_blk)
    );

    function automatic logic [31:0] img(logic [35:0] a, logic en);
        return {a[35:15], en, 1'b1, 9'd5};
    endfunction

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
    endtask

    task automatic probe(string req, logic [35:0] a, logic hit, logic [8:0] blk);
        req_addr = a;
        #1;
        check({req, " hit"}, 36'(win_hit), 36'(hit));
        check({req, " blk"}, 36'(win_blk), 36'(blk));
    endtask

    task automatic t_reset;
        access_ok = 1'b1;
        #1;
        check("R1 reset readback", 36'(reg_rd_data), 36'(32'h0000_0205));
        probe("R1 reset no hit", 36'h0, 1'b0, 9'd0);
    endtask

    task automatic t_all_ones;
        wr(32'hFFFF_FFFF);
        check("R2 R3 R4 all-ones readback", 36'(reg_rd_data), 36'(32'h0FFF_FE05));
    endtask

    task automatic t_write_base;
        wr({B[35:15], 1'b1, 10'd0});
        check("R2 base readback", 36'(reg_rd_data), 36'(img(B, 1'b1)));
    endtask

    task automatic t_decode;
        probe("R9 blk0", B + 36'h3F, 1'b1, 9'd0);
        probe("R8 last blk", B + 36'd5 * 64 + 36'd4, 1'b1, 9'd5);
        probe("R8 past end", B + 36'd6 * 64, 1'b0, 9'd0);
        probe("R8 top of page", B + 36'h7FC0, 1'b0, 9'd0);
        probe("R7 next page", B + 36'h8000, 1'b0, 9'd0);
        probe("R7 unimpl bit", B | 36'h2_0000_0000, 1'b0, 9'd0);
        // R10: address change alone, no clock edge
        req_addr = B + 36'd2 * 64;
        #1;
        check("R10 comb hit", 36'(win_hit), 36'd1);
        check("R10 comb blk", 36'(win_blk), 36'd2);
    endtask

    task automatic t_disabled;
        wr({B[35:15], 1'b0, 10'd0});
        check("R2 enable cleared", 36'(reg_rd_data), 36'(img(B, 1'b0)));
        probe("R6 disabled blk0", B, 1'b0, 9'd0);
        probe("R6 disabled blk5", B + 36'd5 * 64, 1'b0, 9'd0);
        wr({B[35:15], 1'b1, 10'd0});
        probe("R6 re-enabled", B + 36'd5 * 64, 1'b1, 9'd5);
    endtask

    task automatic t_permission;
        @(negedge clk);
        access_ok = 1'b0;
        #1;
        check("R5 read blocked", 36'(reg_rd_data), 36'd0);
        wr(32'h0000_0000);
        access_ok = 1'b1;
        #1;
        check("R5 write dropped", 36'(reg_rd_data), 36'(img(B, 1'b1)));
        probe("R5 still hits", B + 36'd1 * 64, 1'b1, 9'd1);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 re-reset readback", 36'(reg_rd_data), 36'(32'h0000_0205));
        probe("R1 re-reset no hit", B, 1'b0, 9'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_all_ones();
        t_write_base();
        t_decode();
        t_disabled();
        t_permission();
        t_reset_again();
        finish_run();
    end

endmodule